// File: doc/BRIEF.md
# Carry-Save Tree Multiplier

An unsigned multiplier that takes two 8-bit operands and returns their 16-bit product one clock after the operands are presented. Each bit of the second operand gates a copy of the first operand, shifted to that bit's weight. This gives eight partial-product rows. Layers of 3:2 full-adder compressors reduce these rows without carry propagation, in the fixed count 8 → 6 → 4 → 3 → 2. A single ripple carry-propagate adder then sums the last two rows, and a register captures the result.

All rows are the full product width, and any position a row does not cover is filled with zero. Each compressor turns three rows into a sum row and a carry row, and the carry row is moved up one weight before it enters the next layer. Every layer is a separately instantiated stage, so its depth and its row count can be inspected on their own. The operand width is a parameter. The layer count and the row count of each layer follow from it.

Top module: `csa_mult`

## Requirements
- R1: While `rst_ni` is low, `prod_o` is zero.
- R2: After each rising clock edge with reset released, `prod_o` equals the unsigned product of the `a_i` and `b_i` values present at that edge.
- R3: Partial-product row i equals `a_i` shifted left by i when bit i of `b_i` is 1, and zero otherwise. With `b_i` = 1<<i, the product is therefore `a_i`<<i.
- R4: Each compressor layer preserves the modulo-2^16 sum of its rows. The row counts per layer are 8, 6, 4, 3 and then 2.
- R5: The final adder propagates carries across all 16 bits, so 255 × 255 gives 16'hFE01.
- R6: If either operand is zero, the product after the next edge is zero.
- R7: If the operands are held for two consecutive edges, `prod_o` does not change after the second of them.
- R8: The product is correct for every one of the 65,536 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned; bit i selects row i |
| prod_o | output | 16 | Registered unsigned product |

## Verification
The hardest case to reach from the ports is a carry that travels the full length of the final adder. At the same moment, every compressor must have all three of its inputs set, so that both sum and carry rows are non-zero in every layer. All-ones operands, dense alternating patterns and one-hot multipliers create these conditions directly. A sweep over every operand pair, issued one pair per clock, then covers every carry pattern the tree can produce.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;
  // rows left after one 3:2 layer
  function automatic int layer_out(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // rows entering layer l
  function automatic int rows_at(input int n, input int l);
    int r;
    r = n;
    for (int k = 0; k < l; k++) r = layer_out(r);
    return r;
  endfunction

  function automatic int num_layers(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = layer_out(r);
      c++;
    end
    return c;
  endfunction
endpackage

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
  parameter int OP_W = 8,
  parameter int PW   = 2 * OP_W
) (
  input  logic [OP_W-1:0]          a_i,
  input  logic [OP_W-1:0]          b_i,
  output logic [OP_W-1:0][PW-1:0]  rows_o
);
  logic [PW-1:0] a_ext;
  assign a_ext = PW'(a_i);

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    assign rows_o[i] = (a_ext << i) & {PW{b_i[i]}};
  end

  logic [PW-1:0] row_total;
  always_comb begin
    row_total = '0;
    for (int i = 0; i < OP_W; i++) row_total = row_total + rows_o[i];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i}))
      AST_PP_TOTAL: assert (row_total == PW'(a_i) * PW'(b_i)); // R3
  end
endmodule

// File: rtl/csa_layer.sv
module csa_layer #(
  parameter int W     = 16,
  parameter int R_MAX = 8,
  parameter int N_IN  = 8
) (
  input  logic [R_MAX-1:0][W-1:0] rows_i,
  output logic [R_MAX-1:0][W-1:0] rows_o
);
  localparam int GRP   = N_IN / 3;
  localparam int REST  = N_IN % 3;
  localparam int N_OUT = 2 * GRP + REST;

  logic [R_MAX-1:0][W-1:0] cmp;

  for (genvar g = 0; g < GRP; g++) begin : g_fa
    logic [W-1:0] x, y, z;
    assign x = rows_i[3*g];
    assign y = rows_i[3*g+1];
    assign z = rows_i[3*g+2];
    assign cmp[2*g]   = x ^ y ^ z;
    assign cmp[2*g+1] = ((x & y) | (x & z) | (y & z)) << 1;
  end

  for (genvar k = 0; k < REST; k++) begin : g_pass
    assign cmp[2*GRP+k] = rows_i[3*GRP+k];
  end

  for (genvar r = N_OUT; r < R_MAX; r++) begin : g_zero
    assign cmp[r] = '0;
  end

  assign rows_o = cmp;

  logic [W-1:0] sum_in, sum_out;
  always_comb begin
    sum_in  = '0;
    sum_out = '0;
    for (int r = 0; r < R_MAX; r++) begin
      sum_in  = sum_in + rows_i[r];
      sum_out = sum_out + rows_o[r];
    end
  end

  always_comb begin
    if (!$isunknown(rows_i)) begin
      AST_LAYER_SUM: assert (sum_in == sum_out); // R4
    end
  end
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum_o[k]  = x_i[k] ^ y_i[k] ^ cy[k];
    assign cy[k+1]   = (x_i[k] & y_i[k]) | (cy[k] & (x_i[k] ^ y_i[k]));
  end

  always_comb begin
    if (!$isunknown({x_i, y_i}))
      AST_CPA_SUM: assert (sum_o == W'(x_i + y_i)); // R5
  end
endmodule

// File: rtl/csa_mult.sv
module csa_mult #(
  parameter int OP_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OP_W-1:0]     a_i,
  input  logic [OP_W-1:0]     b_i,
  output logic [2*OP_W-1:0]   prod_o
);
  import csa_mult_pkg::*;

  localparam int PW = 2 * OP_W;
  localparam int NL = num_layers(OP_W);

  logic [NL:0][OP_W-1:0][PW-1:0] stg;
  logic [PW-1:0]                 sum_d;

  csa_pp_gen #(.OP_W(OP_W), .PW(PW)) u_pp (
    .a_i    (a_i),
    .b_i    (b_i),
    .rows_o (stg[0])
  );

  for (genvar l = 0; l < NL; l++) begin : g_layer
    csa_layer #(.W(PW), .R_MAX(OP_W), .N_IN(rows_at(OP_W, l))) u_layer (
      .rows_i (stg[l]),
      .rows_o (stg[l+1])
    );
  end

  csa_cpa #(.W(PW)) u_cpa (
    .x_i   (stg[NL][0]),
    .y_i   (stg[NL][1]),
    .sum_o (sum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= sum_d;
  end

  AST_PROD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> prod_o == PW'($past(a_i)) * PW'($past(b_i))); // R2

  AST_ZERO_PROD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |=> prod_o == '0); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(a_i) && $stable(b_i)) |=> $stable(prod_o)); // R7

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_ZERO: assert (prod_o == '0); // R1
endmodule

// File: tb/csa_mult_bench.sv
module csa_mult_bench;
  localparam int OP_W = 8;
  localparam int PW   = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [OP_W-1:0] a_i = '0;
  logic [OP_W-1:0] b_i = '0;
  logic [PW-1:0]   prod_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [PW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk_i = ~clk_i;

  csa_mult #(.OP_W(OP_W)) u_csa_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o)
  );

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    exp_q.push_back(16'(a) * 16'(b));
    tag_q.push_back(tag);
  endtask

  // monitor: result of a pair pushed at a negedge is sampled mid-high after the next rise
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (rst_ni && exp_q.size() > 0) begin
        logic [PW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (prod_o !== e) begin
          errors++;
          $display("FAIL %s: a*b got %h expected %h", t, prod_o, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    a_i = 8'hA5;
    b_i = 8'h3C;
    repeat (3) @(posedge clk_i);
    #5;
    checks++; // R1
    if (prod_o !== '0) begin
      errors++;
      $display("FAIL R1: prod_o got %h expected 0000", prod_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: operands change every cycle
    drive(8'd3, 8'd7, "R2");
    drive(8'd200, 8'd2, "R2");
    drive(8'd17, 8'd19, "R2");
    drive(8'd1, 8'd1, "R2");
    // R3: one-hot multiplier selects a single shifted row
    for (int i = 0; i < 8; i++) drive(8'hB7, 8'(1 << i), "R3");
    // R4: dense patterns fill every compressor input
    drive(8'hAA, 8'hFF, "R4");
    drive(8'h55, 8'hFF, "R4");
    drive(8'hFF, 8'hAA, "R4");
    drive(8'hF0, 8'h0F, "R4");
    // R5: longest carry run
    drive(8'hFF, 8'hFF, "R5");
    drive(8'hFF, 8'hFE, "R5");
    // R6: zero operand
    drive(8'h00, 8'hFF, "R6");
    drive(8'hFF, 8'h00, "R6");
    // R7: held operands keep output steady
    for (int k = 0; k < 3; k++) drive(8'h9D, 8'h6B, "R7");
    // R8: every operand pair
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        drive(8'(a), 8'(b), "R8");

    while (exp_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule